// File: doc/BRIEF.md
# Remote-Control Infrared Transmit Modulator

This block turns a stream of code bytes into the drive signal for an infrared LED used by consumer remote-control links. Each byte is taken from a transmit queue through a valid/ready handshake and sent as eight raw bits, least significant first, one bit per baud tick. No framing bits are added. A bit of value 1 leaves the LED dark. A bit of value 0 lights it with a sub-carrier whose period and high time, both in clock cycles, come from configuration inputs.

A mode input chooses how a run of zeros is modulated. In continuous mode the carrier runs for the whole run. In the two burst modes a fixed number of carrier pulses (six or eight) is sent at the start of each run, and later zeros in that run add no pulses. A run that ends early cuts the burst short. The baud divider lives outside the block and supplies a one-cycle tick.

A transmission ends normally at a byte that carries the end tag. If the queue has no byte ready when the last bit of an untagged byte finishes, the block raises a sticky underrun flag. It will not start again until software pulses the clear input.

Top module: `remote_ir_tx`

## Requirements
- R1: A transmission starts only on a clock where `baudTick`, `inValid` and `inReady` are all high. From that edge each byte is sent as bits 0 to 7 in that order, one bit for each baud-tick interval, with no start, stop or parity bits.
- R2: While the bit being sent is 1, and whenever the block is idle, `ledOut` stays low.
- R3: In continuous mode (`burstMode` 2'b00 or 2'b11), a zero run of D cycles produces carrier pulses of period `carrierPeriod` with `carrierHigh` high cycles each, starting with a pulse. That gives ceil(D/period) rising edges and floor(D/period)*high + min(D mod period, high) high cycles. `ledOut` is registered, one cycle behind the bit.
- R4: In burst mode `burstMode`=2'b01 exactly 6 pulses, and in 2'b10 exactly 8 pulses, are emitted at the start of each zero run that lasts at least that many carrier periods. Further zeros in the run emit nothing.
- R5: A zero run shorter than the burst length truncates the burst. It then produces the same pulses as continuous mode would for that run.
- R6: When the next byte is valid at the final bit's tick of an untagged byte, it is taken in that same cycle with no gap. A zero run that crosses the byte boundary counts as one run.
- R7: After the last bit of a byte whose `inLast` tag was set, `busy` falls, `ledOut` returns low and `underrun` stays 0.
- R8: If the last bit of an untagged byte ends while `inValid` is low, `underrun` is set. While it is set, `inReady` stays low and nothing is sent. A one-cycle pulse on `underrunClr` clears it.
- R9: After reset, `ledOut`, `busy` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | DATA_W | Code byte from the transmit queue |
| inLast | input | 1 | End-of-transmission tag for `inData` |
| inValid | input | 1 | Queue holds a byte |
| inReady | output | 1 | Byte is taken on this clock when `inValid` is high |
| baudTick | input | 1 | One-cycle bit-rate strobe |
| carrierPeriod | input | CNT_W | Carrier period in clock cycles (at least 2) |
| carrierHigh | input | CNT_W | High cycles per carrier period |
| burstMode | input | 2 | 00/11 continuous, 01 six-pulse, 10 eight-pulse |
| underrunClr | input | 1 | Clears the underrun flag |
| ledOut | output | 1 | LED drive, high means LED on |
| busy | output | 1 | A byte is being shifted out |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The hardest situation to reach is the interaction between burst truncation and runs that cross byte boundaries. It needs a zero run whose length in cycles falls just below, at, or above the burst length times the carrier period, and that may also span back-to-back bytes. The stimulus does this with directed frames (two zero bytes in six-pulse mode, and a single zero bit in eight-pulse mode with a period close to the bit time). Randomly drawn frames then sweep the carrier period, high time, bit time and mode. The expected pulse count, high-cycle total and first-pulse position are computed from the bit runs for each frame. The underrun lockout is reached by leaving a byte untagged and then holding a valid byte at the input across several ticks.

// File: rtl/remote_ir_tx_pkg.sv
package remote_ir_tx_pkg;

  typedef enum logic [1:0] {
    MODE_CONT     = 2'b00,
    MODE_SIX      = 2'b01,
    MODE_EIGHT    = 2'b10,
    MODE_CONT_ALT = 2'b11
  } modSel_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new byte
    logic shift;   // advance to the next bit
    logic active;  // a bit is on the line
  } txStrobe_t;

endpackage

// File: rtl/remote_ir_tx_ctrl.sv
module remote_ir_tx_ctrl
  import remote_ir_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      baudTick,
  input  logic      underrunClr,
  output logic      inReady,
  output logic      busy,
  output logic      underrun,
  output txStrobe_t strobe
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  txState_t stateQ;
  logic [BIT_W-1:0] bitQ;
  logic lastQ;
  logic underrunQ;

  logic sending, lastBitTick, takeIdle, takeChain, take;

  always_comb begin
    sending     = (stateQ == ST_SEND);
    lastBitTick = sending && baudTick && (bitQ == LAST_BIT);
    takeIdle    = !sending && !underrunQ && baudTick;
    takeChain   = lastBitTick && !lastQ;
    inReady     = takeIdle || takeChain;
    take        = inReady && inValid;
    strobe.load   = take;
    strobe.shift  = sending && baudTick && !lastBitTick;
    strobe.active = sending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      bitQ   <= '0;
      lastQ  <= 1'b0;
    end else if (take) begin
      stateQ <= ST_SEND;
      bitQ   <= '0;
      lastQ  <= inLast;
    end else if (lastBitTick) begin
      stateQ <= ST_IDLE;
      bitQ   <= '0;
    end else if (sending && baudTick) begin
      bitQ <= bitQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      underrunQ <= 1'b0;
    end else if (lastBitTick && !lastQ && !inValid) begin
      underrunQ <= 1'b1;
    end else if (underrunClr) begin
      underrunQ <= 1'b0;
    end
  end

  assign busy     = sending;
  assign underrun = underrunQ;

  // R1: sending begins only on a baud tick
  assert_start_on_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(baudTick));

  // R8: flag holds until cleared
  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    underrun && !underrunClr |=> underrun);

  // R8: no new transmission while flagged
  assert_underrun_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    underrun && !underrunClr && !busy |=> !busy);

  // R8: flag rises only after an unfed final bit
  assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(busy) && !$past(inValid));

endmodule

// File: rtl/remote_ir_tx_dp.sv
module remote_ir_tx_dp
  import remote_ir_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int BURST_SHORT = 6,
  parameter int BURST_LONG  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [CNT_W-1:0]  carrierPeriod,
  input  logic [CNT_W-1:0]  carrierHigh,
  input  logic [1:0]        burstMode,
  output logic              ledOut
);

  localparam int BC_W = $clog2(BURST_LONG + 1);

  logic [DATA_W-1:0] shiftQ;
  logic [CNT_W-1:0]  phaseQ;
  logic [BC_W-1:0]   burstQ;
  logic              ledQ;

  logic            zeroActive, wrap, burstOn, burstSpent, pulseOn;
  logic [BC_W-1:0] burstLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '1;
    end else if (strobe.load) begin
      shiftQ <= inData;
    end else if (strobe.shift) begin
      shiftQ <= {1'b1, shiftQ[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (modSel_t'(burstMode))
      MODE_SIX: begin
        burstOn    = 1'b1;
        burstLimit = BC_W'(BURST_SHORT);
      end
      MODE_EIGHT: begin
        burstOn    = 1'b1;
        burstLimit = BC_W'(BURST_LONG);
      end
      default: begin
        burstOn    = 1'b0;
        burstLimit = '0;
      end
    endcase
    zeroActive = strobe.active && !shiftQ[0];
    wrap       = ({1'b0, phaseQ} + (CNT_W + 1)'(1)) >= {1'b0, carrierPeriod};
    burstSpent = burstOn && (burstQ >= burstLimit);
    pulseOn    = zeroActive && (phaseQ < carrierHigh) && !burstSpent;
  end

  // carrier phase and burst pulse counting, cleared outside zero runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
      burstQ <= '0;
    end else if (!zeroActive) begin
      phaseQ <= '0;
      burstQ <= '0;
    end else begin
      phaseQ <= wrap ? '0 : phaseQ + 1'b1;
      if (wrap && (burstQ < burstLimit)) burstQ <= burstQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ledQ <= 1'b0;
    else       ledQ <= pulseOn;
  end

  assign ledOut = ledQ;

  // R2: dark whenever no zero bit is on the line
  assert_dark_on_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    !zeroActive |=> !ledOut);

  // R4: burst closed after its pulse count
  assert_burst_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    burstOn && (burstQ == burstLimit) |=> !ledOut);

  // R3: phase stays inside the programmed period
  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    zeroActive && (carrierPeriod >= 2) |-> phaseQ < carrierPeriod);

endmodule

// File: rtl/remote_ir_tx.sv
module remote_ir_tx
  import remote_ir_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int BURST_SHORT = 6,
  parameter int BURST_LONG  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              inValid,
  output logic              inReady,
  input  logic              baudTick,
  input  logic [CNT_W-1:0]  carrierPeriod,
  input  logic [CNT_W-1:0]  carrierHigh,
  input  logic [1:0]        burstMode,
  input  logic              underrunClr,
  output logic              ledOut,
  output logic              busy,
  output logic              underrun
);

  txStrobe_t strobe;

  remote_ir_tx_ctrl #(
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inLast     (inLast),
    .baudTick   (baudTick),
    .underrunClr(underrunClr),
    .inReady    (inReady),
    .busy       (busy),
    .underrun   (underrun),
    .strobe     (strobe)
  );

  remote_ir_tx_dp #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .BURST_SHORT(BURST_SHORT),
    .BURST_LONG (BURST_LONG)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .inData       (inData),
    .carrierPeriod(carrierPeriod),
    .carrierHigh  (carrierHigh),
    .burstMode    (burstMode),
    .ledOut       (ledOut)
  );

endmodule

// File: tb/remote_ir_tx_tb.sv
module remote_ir_tx_tb;

  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = '0;
  logic       inLast = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       baudTick = 1'b0;
  logic [7:0] carrierPeriod = 8'd4;
  logic [7:0] carrierHigh = 8'd2;
  logic [1:0] burstMode = 2'b00;
  logic       underrunClr = 1'b0;
  logic       ledOut, busy, underrun;

  int compared = 0;
  int mismatched = 0;
  int tickPeriod = 10;
  int tcnt = 0;
  bit finished = 0;
  logic [7:0] frameBytes [0:7];

  remote_ir_tx u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inLast(inLast),
    .inValid(inValid), .inReady(inReady), .baudTick(baudTick),
    .carrierPeriod(carrierPeriod), .carrierHigh(carrierHigh),
    .burstMode(burstMode), .underrunClr(underrunClr),
    .ledOut(ledOut), .busy(busy), .underrun(underrun)
  );

  always #(CLK_NS / 2) clk = ~clk;

  // baud strobe source, one cycle every tickPeriod cycles
  always @(negedge clk) begin
    if (!rstN) begin
      tcnt     <= 0;
      baudTick <= 1'b0;
    end else if (tcnt >= tickPeriod - 1) begin
      tcnt     <= 0;
      baudTick <= 1'b1;
    end else begin
      tcnt     <= tcnt + 1;
      baudTick <= 1'b0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected pulse edges, high cycles and first-pulse offset from the bit runs
  task automatic expectRuns(input int n, input int t, input int p, input int h,
                            input logic [1:0] mode, output int ePulses,
                            output int eHigh, output int eFirst);
    int burstN;
    int run;
    burstN  = (mode == 2'b01) ? 6 : (mode == 2'b10) ? 8 : 0;
    ePulses = 0;
    eHigh   = 0;
    eFirst  = -1;
    run     = 0;
    for (int i = 0; i <= 8 * n; i++) begin
      bit zero;
      zero = (i < 8 * n) ? !frameBytes[i / 8][i % 8] : 1'b0;
      if (zero) begin
        if (eFirst < 0) eFirst = i * t + 2;
        run++;
      end else if (run > 0) begin
        int d, full, rem;
        d    = run * t;
        full = d / p;
        rem  = d % p;
        if (burstN > 0 && full >= burstN) begin
          ePulses += burstN;
          eHigh   += burstN * h;
        end else begin
          ePulses += full + ((rem > 0) ? 1 : 0);
          eHigh   += full * h + ((rem < h) ? rem : h);
        end
        run = 0;
      end
    end
  endtask

  task automatic runFrame(input int n, input bit tagLast, input int t, input int p,
                          input int h, input logic [1:0] mode, input string req);
    int acc, iter, cA, pulses, highs, firstRise, tail;
    int ePulses, eHigh, eFirst;
    bit pend, prevLed, done;
    @(negedge clk);
    tickPeriod    = t;
    carrierPeriod = 8'(p);
    carrierHigh   = 8'(h);
    burstMode     = mode;
    repeat (2 * t + 2) @(negedge clk);
    expectRuns(n, t, p, h, mode, ePulses, eHigh, eFirst);
    acc = 0; iter = 0; cA = -1; pulses = 0; highs = 0; firstRise = -1; tail = 0;
    pend = 0; prevLed = 0; done = 0;
    while (!done && iter < 40000) begin
      @(negedge clk);
      #1;
      if (pend) begin
        acc++;
        pend = 0;
      end
      if (ledOut) begin
        highs++;
        if (!prevLed) begin
          pulses++;
          if (firstRise < 0 && cA >= 0) firstRise = iter - cA;
        end
      end
      prevLed = ledOut;
      if (acc == n && !busy) begin
        tail++;
        if (tail > 4) done = 1;
      end
      inValid = (acc < n);
      inData  = frameBytes[(acc < 8) ? acc : 7];
      inLast  = tagLast && (acc == n - 1);
      #1;
      if (inValid && inReady) begin
        pend = 1;
        if (cA < 0) cA = iter;
      end
      iter++;
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    check(req, "frame completes", int'(done), 1);
    check(req, "pulse count", pulses, ePulses);
    check(req, "high cycles", highs, eHigh);
    check("R1", "first pulse offset", firstRise, eFirst);
    check("R2", "led dark after frame", int'(ledOut), 0);
    check("R7", "busy low after frame", int'(busy), 0);
    check(tagLast ? "R7" : "R8", "underrun flag", int'(underrun), tagLast ? 0 : 1);
  endtask

  task automatic clearUnderrun();
    @(negedge clk);
    underrunClr = 1'b1;
    @(negedge clk);
    underrunClr = 1'b0;
    #1;
    check("R8", "flag cleared", int'(underrun), 0);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd20241));
    repeat (5) @(negedge clk);
    #1;
    check("R9", "reset led", int'(ledOut), 0);
    check("R9", "reset busy", int'(busy), 0);
    check("R9", "reset underrun", int'(underrun), 0);
    rstN = 1'b1;

    // R1/R3: 0x01 gives a one bit then seven zeros
    frameBytes[0] = 8'h01;
    runFrame(1, 1'b1, 10, 4, 2, 2'b00, "R3");

    // R6/R4: two zero bytes form one 16-bit run, six pulses only
    frameBytes[0] = 8'h00;
    frameBytes[1] = 8'h00;
    runFrame(2, 1'b1, 8, 3, 1, 2'b01, "R6");

    // R5: single zero bit shorter than the eight-pulse burst
    frameBytes[0] = 8'hFD;
    runFrame(1, 1'b1, 6, 5, 2, 2'b10, "R5");

    // R4: eight-pulse burst fully emitted
    frameBytes[0] = 8'hF0;
    runFrame(1, 1'b1, 12, 4, 3, 2'b10, "R4");

    // R8: untagged byte leads to underrun
    frameBytes[0] = 8'hAA;
    runFrame(1, 1'b0, 10, 4, 2, 2'b00, "R8");

    // R8/R2: held valid byte is refused while flagged, LED stays dark
    seen = 0;
    for (int c = 0; c < 6 * tickPeriod; c++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = 8'h00;
      inLast  = 1'b1;
      #1;
      if (inReady || busy || ledOut) seen++;
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    check("R8", "refused while flagged", seen, 0);
    check("R2", "led dark while flagged", int'(ledOut), 0);
    clearUnderrun();

    frameBytes[0] = 8'h3C;
    runFrame(1, 1'b1, 10, 4, 2, 2'b00, "R8");

    // random frames across modes and carrier settings
    for (int k = 0; k < 24; k++) begin
      int p, h, t, n;
      logic [1:0] m;
      bit tg;
      p  = 2 + int'($urandom % 11);
      h  = 1 + int'($urandom % (p - 1));
      t  = p + int'($urandom % (2 * p + 1));
      m  = 2'($urandom % 4);
      n  = 1 + int'($urandom % 4);
      tg = ($urandom % 4) != 0;
      for (int b = 0; b < n; b++) frameBytes[b] = 8'($urandom);
      runFrame(n, tg, t, p, h, m, (m == 2'b01 || m == 2'b10) ? "R4" : "R3");
      if (!tg) clearUnderrun();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule